// File: doc/BRIEF.md
# CPU Control Register Decoder

This block sits on the main processor's bus and turns write cycles aimed at the upper half of the address space into control actions. Some address ranges only need to produce an event. A write to the watchdog range produces a one-clock kick, and a write to the acknowledge range produces a one-clock interrupt acknowledge. Other ranges load registers that the video and memory logic hold on to: four tilemap scroll/priority settings (two tilemap pairs of two maps each), two 2-bit program ROM bank numbers, a single tile graphics bank bit and an 8-bit background colour.

A write cycle is the span in which `wr_en` is high. Only the first clock of that span acts, so a strobe held for several clocks still counts as one write. Inside each tilemap-pair range, the three lowest address bits choose the field. Bit 2 picks the map within the pair, and bits 1:0 pick the part. The graphics bank bit takes its value from address bit 10 and does not look at the data bus.

The block also drives the program ROM address for reads. A read in the 0x6000–0x7FFF window is steered to the banked ROM, using the main bank number as the upper address bits. Any address with bit 15 set selects the fixed ROM.

Top module: `cpu_ctl_decoder`

## Requirements
- R1: The first clock of a write cycle to 0x8000–0x83FF makes `wdog_kick` high for the next clock.
- R2: The first clock of a write cycle to 0x8400–0x87FF makes `irq_ack` high for the next clock.
- R3: Each write cycle yields exactly one strobe clock, even when `wr_en` stays high for several clocks. A later pulse requires `wr_en` to go low first.
- R4: A write to 0x8800–0x8FFF sets `gfx_bank` to address bit 10 and ignores `wdata`.
- R5: Writes to 0x9000–0x93FF reach tilemaps 0/1, and writes to 0x9400–0x97FF reach tilemaps 2/3. The map index is 2×pair plus address bit 2. When A1:A0=00, the map's priority takes `wdata[3:1]` and its X scroll bit 8 takes `wdata[0]`. When A1:A0=01, X scroll bits 7:0 take `wdata`.
- R6: In either tilemap-pair range, A1:A0=10 loads the 8-bit Y scroll of the map chosen by A2 from `wdata`.
- R7: In either tilemap-pair range, A1:A0=11 loads a bank number from `wdata[1:0]`. Pair 0/1 writes `main_bank`, pair 2/3 writes `sub_bank`, and A2 has no effect.
- R8: A write to 0xC000–0xC3FF loads `bg_color` from `wdata`.
- R9: `rom_addr` is always {`main_bank`, A12..A0}. `rom_bank_sel` is high exactly when A15..A13=011. `rom_fixed_sel` is high exactly when A15=1.
- R10: After reset, every register is zero and both strobes are low.
- R11: Writes outside the listed control ranges leave every register and strobe unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Processor address bus |
| wdata | input | 8 | Processor write data |
| wr_en | input | 1 | Write strobe, high for the whole write cycle |
| wdog_kick | output | 1 | One-clock watchdog kick |
| irq_ack | output | 1 | One-clock interrupt acknowledge |
| gfx_bank | output | 1 | Tile graphics bank bit |
| bg_color | output | 8 | Background colour register |
| main_bank | output | 2 | Main program ROM bank |
| sub_bank | output | 2 | Sub program ROM bank |
| scroll_x | output | 4×9 | X scroll per tilemap, map 3 in the top slice |
| scroll_prio | output | 4×3 | Priority per tilemap |
| scroll_y | output | 4×8 | Y scroll per tilemap |
| rom_addr | output | 15 | Banked program ROM address |
| rom_bank_sel | output | 1 | Read targets the banked window |
| rom_fixed_sel | output | 1 | Read targets the fixed ROM |

## Verification
Registers and strobes change on the clock edge that samples the first high `wr_en`. They are therefore due one clock after the stimulus is driven. A strobe must be low again two clocks after the stimulus and must stay low while `wr_en` is still held. The ROM select outputs and address are combinational. They are checked one clock after the address is applied, and that check also covers a bank change made by the previous write. Each write makes the driver queue a complete snapshot of every output, tagged with the clock it falls due in. The monitor compares only the items whose clock has arrived, which also catches side effects of writes that should have none.

// File: rtl/cpu_ctl_pkg.sv
// Shared constants and types for the CPU control register decoder.
// Assumes a 16-bit address bus and an 8-bit data bus.
package cpu_ctl_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int NUM_PAIRS = 2;
    localparam int NUM_MAPS  = 2 * NUM_PAIRS;
    localparam int WIN_W     = 13;           // banked window offset width

    // Field code carried by A1:A0 inside a tilemap-pair range
    typedef enum logic [1:0] {
        FLD_XHI  = 2'b00,
        FLD_XLO  = 2'b01,
        FLD_Y    = 2'b10,
        FLD_BANK = 2'b11
    } fld_t;

    // A15..A10 codes of the 1 KiB control ranges
    localparam logic [5:0] PG_WDOG = 6'b100000;
    localparam logic [5:0] PG_IRQ  = 6'b100001;
    localparam logic [4:0] PG_GFX  = 5'b10001;   // 2 KiB range, A15..A11
    localparam logic [4:0] PG_LAT  = 5'b10010;   // A10 picks the pair
    localparam logic [5:0] PG_BG   = 6'b110000;
    localparam logic [2:0] PG_WIN  = 3'b011;     // A15..A13 banked window
endpackage

// File: rtl/cpu_ctl_addr_decode.sv
// Address decoder: turns the high address bits into one qualified hit per
// control range and splits the low bits into map select and field code.
// Assumes the caller gives a one-clock write-start pulse.
module cpu_ctl_addr_decode
    import cpu_ctl_pkg::*;
#(
    parameter int PAIRS = NUM_PAIRS
) (
    input  logic             wr_start,
    input  logic [5:0]       addr_hi,     // A15..A10
    input  logic [2:0]       addr_lo,     // A2..A0
    output logic             hit_wdog,
    output logic             hit_irq,
    output logic             hit_gfx,
    output logic             hit_bg,
    output logic [PAIRS-1:0] hit_lat,
    output logic             map_sel,
    output fld_t             fld
);
    // Event and single-register ranges
    always_comb begin
        hit_wdog = wr_start && (addr_hi == PG_WDOG);
        hit_irq  = wr_start && (addr_hi == PG_IRQ);
        hit_gfx  = wr_start && (addr_hi[5:1] == PG_GFX);
        hit_bg   = wr_start && (addr_hi == PG_BG);
    end

    // One latch range per tilemap pair, chosen by A10
    for (genvar p = 0; p < PAIRS; p++) begin : g_lat
        always_comb begin
            hit_lat[p] = wr_start && (addr_hi[5:1] == PG_LAT)
                         && (addr_hi[0] == 1'(p));
        end
    end

    // Sub-addressing inside a latch range
    always_comb begin
        map_sel = addr_lo[2];
        fld     = fld_t'(addr_lo[1:0]);
    end
endmodule

// File: rtl/cpu_ctl_strobe_gen.sv
// Write-cycle edge detector and strobe register stage.
// Makes a one-clock start pulse from the first clock of each wr_en span and
// registers the event strobes so each lasts exactly one clock.
module cpu_ctl_strobe_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic hit_wdog,
    input  logic hit_irq,
    output logic wr_start,
    output logic wdog_kick,
    output logic irq_ack
);
    logic wr_prev;

    // Remember the write strobe of the previous clock
    always_ff @(posedge clk) begin
        if (!rst_n) wr_prev <= 1'b0;
        else        wr_prev <= wr_en;
    end

    // First clock of a write cycle
    always_comb wr_start = wr_en && !wr_prev;

    // Register the event strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdog_kick <= 1'b0;
            irq_ack   <= 1'b0;
        end else begin
            wdog_kick <= hit_wdog;
            irq_ack   <= hit_irq;
        end
    end
endmodule

// File: rtl/cpu_ctl_scroll_latch.sv
// Scroll/priority latch for one tilemap pair, plus that pair's ROM bank.
// Assumes XW = DW + 1: the X scroll high bit is loaded with the priority.
module cpu_ctl_scroll_latch
    import cpu_ctl_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int XW = DATA_W + 1,
    parameter int PW = 3,
    parameter int YW = DATA_W,
    parameter int BW = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               map_sel,
    input  fld_t               fld,
    input  logic [DW-1:0]      wdata,
    output logic [1:0][XW-1:0] x_q,
    output logic [1:0][PW-1:0] prio_q,
    output logic [1:0][YW-1:0] y_q,
    output logic [BW-1:0]      bank_q
);
    // Per-map scroll and priority fields
    for (genvar m = 0; m < 2; m++) begin : g_map
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                x_q[m]    <= '0;
                prio_q[m] <= '0;
                y_q[m]    <= '0;
            end else if (load && (map_sel == 1'(m))) begin
                case (fld)
                    FLD_XHI: begin
                        prio_q[m]    <= wdata[PW:1];
                        x_q[m][XW-1] <= wdata[0];
                    end
                    FLD_XLO: x_q[m][DW-1:0] <= wdata;
                    FLD_Y:   y_q[m]         <= wdata[YW-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Bank number, shared by both maps of the pair
    always_ff @(posedge clk) begin
        if (!rst_n)                       bank_q <= '0;
        else if (load && fld == FLD_BANK) bank_q <= wdata[BW-1:0];
    end
endmodule

// File: rtl/cpu_ctl_misc_regs.sv
// Graphics bank bit and background colour register.
// The bank bit is loaded from an address line; the colour comes from data.
module cpu_ctl_misc_regs
    import cpu_ctl_pkg::*;
#(
    parameter int CW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_gfx,
    input  logic          hit_bg,
    input  logic          addr_a10,
    input  logic [CW-1:0] wdata,
    output logic          gfx_bank,
    output logic [CW-1:0] bg_color
);
    // Graphics bank bit from A10
    always_ff @(posedge clk) begin
        if (!rst_n)       gfx_bank <= 1'b0;
        else if (hit_gfx) gfx_bank <= addr_a10;
    end

    // Background colour from the data bus
    always_ff @(posedge clk) begin
        if (!rst_n)      bg_color <= '0;
        else if (hit_bg) bg_color <= wdata;
    end
endmodule

// File: rtl/cpu_ctl_rom_window.sv
// Program ROM read steering: the banked window is selected by A15..A13 and
// its address is extended with the bank number; A15 selects the fixed ROM.
// Purely combinational.
module cpu_ctl_rom_window
    import cpu_ctl_pkg::*;
#(
    parameter int BW = 2
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BW-1:0]      bank,
    output logic [BW+WIN_W-1:0] rom_addr,
    output logic               bank_sel,
    output logic               fixed_sel
);
    // Window selects and extended address
    always_comb begin
        bank_sel  = (addr[ADDR_W-1 -: 3] == PG_WIN);
        fixed_sel = addr[ADDR_W-1];
        rom_addr  = {bank, addr[WIN_W-1:0]};
    end
endmodule

// File: rtl/cpu_ctl_decoder.sv
// Top of the CPU control register decoder.
// Decodes processor write cycles in the control ranges into strobes and
// registers, and steers ROM reads. Synchronous active-low reset.
module cpu_ctl_decoder
    import cpu_ctl_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int PRIO_W  = 3,
    parameter int COLOR_W = DATA_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wdata,
    input  logic                                wr_en,
    output logic                                wdog_kick,
    output logic                                irq_ack,
    output logic                                gfx_bank,
    output logic [COLOR_W-1:0]                  bg_color,
    output logic [BANK_W-1:0]                   main_bank,
    output logic [BANK_W-1:0]                   sub_bank,
    output logic [NUM_MAPS-1:0][DATA_W:0]       scroll_x,
    output logic [NUM_MAPS-1:0][PRIO_W-1:0]     scroll_prio,
    output logic [NUM_MAPS-1:0][DATA_W-1:0]     scroll_y,
    output logic [BANK_W+WIN_W-1:0]             rom_addr,
    output logic                                rom_bank_sel,
    output logic                                rom_fixed_sel
);
    localparam int XS_W = DATA_W + 1;

    logic                 wr_start;
    logic                 hit_wdog, hit_irq, hit_gfx, hit_bg;
    logic [NUM_PAIRS-1:0] hit_lat;
    logic                 map_sel;
    fld_t                 fld;
    logic [NUM_PAIRS-1:0][BANK_W-1:0] pair_bank;

    cpu_ctl_strobe_gen u_strb (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .hit_wdog  (hit_wdog),
        .hit_irq   (hit_irq),
        .wr_start  (wr_start),
        .wdog_kick (wdog_kick),
        .irq_ack   (irq_ack)
    );

    cpu_ctl_addr_decode #(.PAIRS(NUM_PAIRS)) u_dec (
        .wr_start (wr_start),
        .addr_hi  (addr[ADDR_W-1 -: 6]),
        .addr_lo  (addr[2:0]),
        .hit_wdog (hit_wdog),
        .hit_irq  (hit_irq),
        .hit_gfx  (hit_gfx),
        .hit_bg   (hit_bg),
        .hit_lat  (hit_lat),
        .map_sel  (map_sel),
        .fld      (fld)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        cpu_ctl_scroll_latch #(
            .DW (DATA_W), .XW (XS_W), .PW (PRIO_W), .YW (DATA_W), .BW (BANK_W)
        ) u_lat (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (hit_lat[p]),
            .map_sel (map_sel),
            .fld     (fld),
            .wdata   (wdata),
            .x_q     (scroll_x[2*p +: 2]),
            .prio_q  (scroll_prio[2*p +: 2]),
            .y_q     (scroll_y[2*p +: 2]),
            .bank_q  (pair_bank[p])
        );
    end

    // Pair 0/1 owns the main bank, pair 2/3 the sub bank
    always_comb begin
        main_bank = pair_bank[0];
        sub_bank  = pair_bank[1];
    end

    cpu_ctl_misc_regs #(.CW(COLOR_W)) u_misc (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_gfx  (hit_gfx),
        .hit_bg   (hit_bg),
        .addr_a10 (addr[10]),
        .wdata    (wdata[COLOR_W-1:0]),
        .gfx_bank (gfx_bank),
        .bg_color (bg_color)
    );

    cpu_ctl_rom_window #(.BW(BANK_W)) u_rom (
        .addr      (addr),
        .bank      (main_bank),
        .rom_addr  (rom_addr),
        .bank_sel  (rom_bank_sel),
        .fixed_sel (rom_fixed_sel)
    );
endmodule

// File: rtl/cpu_ctl_decoder_chk.sv
// Assertion checker for cpu_ctl_decoder, attached with bind below.
// Relates strobes and register changes to the bus cycle that caused them.
module cpu_ctl_decoder_chk #(
    parameter int BANK_W  = 2,
    parameter int COLOR_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [15:0]             addr,
    input logic [7:0]              wdata,
    input logic                    wr_en,
    input logic                    wdog_kick,
    input logic                    irq_ack,
    input logic                    gfx_bank,
    input logic [COLOR_W-1:0]      bg_color,
    input logic [BANK_W-1:0]       main_bank,
    input logic [BANK_W-1:0]       sub_bank,
    input logic [BANK_W+12:0]      rom_addr,
    input logic                    rom_bank_sel,
    input logic                    rom_fixed_sel
);
    assert_wdog_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_kick |-> $past(wr_en && addr[15:10] == 6'b100000));

    assert_irq_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> $past(wr_en && addr[15:10] == 6'b100001));

    assert_wdog_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_kick |=> !wdog_kick);

    assert_irq_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    assert_gfx_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gfx_bank) |-> ($past(wr_en && addr[15:11] == 5'b10001)
                                && gfx_bank == $past(addr[10])));

    assert_main_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(main_bank) |->
            $past(wr_en && addr[15:10] == 6'b100100 && addr[1:0] == 2'b11));

    assert_sub_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sub_bank) |->
            $past(wr_en && addr[15:10] == 6'b100101 && addr[1:0] == 2'b11));

    assert_bg_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bg_color) |-> ($past(wr_en && addr[15:10] == 6'b110000)
                                && bg_color == $past(wdata[COLOR_W-1:0])));

    assert_rom_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_bank_sel && rom_fixed_sel));

    assert_rom_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rom_bank_sel |-> rom_addr[BANK_W+12:13] == main_bank);
endmodule

bind cpu_ctl_decoder cpu_ctl_decoder_chk #(.BANK_W(BANK_W), .COLOR_W(COLOR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr          (addr),
    .wdata         (wdata),
    .wr_en         (wr_en),
    .wdog_kick     (wdog_kick),
    .irq_ack       (irq_ack),
    .gfx_bank      (gfx_bank),
    .bg_color      (bg_color),
    .main_bank     (main_bank),
    .sub_bank      (sub_bank),
    .rom_addr      (rom_addr),
    .rom_bank_sel  (rom_bank_sel),
    .rom_fixed_sel (rom_fixed_sel)
);

// File: tb/sim_cpu_ctl_decoder.sv
// Scoreboard bench for cpu_ctl_decoder: the driver queues expected output
// snapshots with the clock they fall due in, and the monitor compares them.
module sim_cpu_ctl_decoder;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       addr = '0;
    logic [7:0]        wdata = '0;
    logic              wr_en = 1'b0;
    logic              wdog_kick, irq_ack, gfx_bank;
    logic [7:0]        bg_color;
    logic [1:0]        main_bank, sub_bank;
    logic [3:0][8:0]   scroll_x;
    logic [3:0][2:0]   scroll_prio;
    logic [3:0][7:0]   scroll_y;
    logic [14:0]       rom_addr;
    logic              rom_bank_sel, rom_fixed_sel;

    cpu_ctl_decoder u0 (.*);

    always #5 clk = ~clk;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        int          sig;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    // Reference model, built from the requirements
    logic       m_gfx;
    logic [7:0] m_bg;
    logic [1:0] m_bank [2];
    logic [8:0] m_x [4];
    logic [2:0] m_p [4];
    logic [7:0] m_y [4];

    function automatic logic [15:0] get_sig(int s);
        case (s)
            0:  return 16'(wdog_kick);
            1:  return 16'(irq_ack);
            2:  return 16'(gfx_bank);
            3:  return 16'(bg_color);
            4:  return 16'(main_bank);
            5:  return 16'(sub_bank);
            18: return 16'(rom_addr);
            19: return 16'(rom_bank_sel);
            20: return 16'(rom_fixed_sel);
            default: begin
                if (s < 10)      return 16'(scroll_x[s-6]);
                else if (s < 14) return 16'(scroll_prio[s-10]);
                else             return 16'(scroll_y[s-14]);
            end
        endcase
    endfunction

    function automatic logic [15:0] model_sig(int s, logic [15:0] a);
        case (s)
            2:  return 16'(m_gfx);
            3:  return 16'(m_bg);
            4:  return 16'(m_bank[0]);
            5:  return 16'(m_bank[1]);
            18: return 16'({m_bank[0], a[12:0]});
            19: return 16'(a[15:13] == 3'b011);
            20: return 16'(a[15]);
            default: begin
                if (s < 10)      return 16'(m_x[s-6]);
                else if (s < 14) return 16'(m_p[s-10]);
                else             return 16'(m_y[s-14]);
            end
        endcase
    endfunction

    task automatic push(int due, int s, logic [15:0] e, string r);
        item_t it;
        it.due = due; it.sig = s; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    // Queue a full register snapshot due in the given clock
    task automatic push_regs(int due, logic [15:0] a, string r);
        for (int s = 2; s <= 20; s++) push(due, s, model_sig(s, a), r);
    endtask

    // Apply one write to the model
    task automatic model_write(logic [15:0] a, logic [7:0] d);
        int t;
        if (a[15:11] == 5'b10001) m_gfx = a[10];
        if (a[15:10] == 6'b110000) m_bg = d;
        if (a[15:11] == 5'b10010) begin
            t = 2 * int'(a[10]) + int'(a[2]);
            case (a[1:0])
                2'b00: begin m_p[t] = d[3:1]; m_x[t][8] = d[0]; end
                2'b01: m_x[t][7:0] = d;
                2'b10: m_y[t] = d;
                default: m_bank[a[10]] = d[1:0];
            endcase
        end
    endtask

    // Driver: one write cycle held for 'hold' clocks
    task automatic do_write(logic [15:0] a, logic [7:0] d, int hold, string r);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        model_write(a, d);
        push(cyc + 1, 0, 16'(a[15:10] == 6'b100000), r);
        push(cyc + 1, 1, 16'(a[15:10] == 6'b100001), r);
        for (int k = 2; k <= hold + 1; k++) begin
            push(cyc + k, 0, 16'h0, r);
            push(cyc + k, 1, 16'h0, r);
        end
        push_regs(cyc + 1, a, r);
        repeat (hold) @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: read address only, no write
    task automatic set_addr(logic [15:0] a, string r);
        @(negedge clk);
        addr = a;
        push_regs(cyc + 1, a, r);
        @(negedge clk);
    endtask

    // Monitor: compare items that fall due in this clock
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                logic [15:0] act;
                act = get_sig(sb[i].sig);
                n_checks++;
                if (act !== sb[i].exp) begin
                    n_fail++;
                    $display("FAIL %s sig=%0d actual=%h expected=%h cyc=%0d",
                             sb[i].req, sb[i].sig, act, sb[i].exp, cyc);
                end
                sb.delete(i);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        m_gfx = 1'b0; m_bg = '0;
        for (int i = 0; i < 2; i++) m_bank[i] = '0;
        for (int i = 0; i < 4; i++) begin m_x[i] = '0; m_p[i] = '0; m_y[i] = '0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        push(cyc + 1, 0, 16'h0, "R10");
        push(cyc + 1, 1, 16'h0, "R10");
        push_regs(cyc + 1, addr, "R10");
        @(negedge clk);

        // R1, R2: strobes at both ends of their ranges
        do_write(16'h8000, 8'h00, 1, "R1");
        do_write(16'h83FF, 8'hFF, 1, "R1");
        do_write(16'h8400, 8'h00, 1, "R2");
        // R3: held strobe gives one pulse
        do_write(16'h87FF, 8'h12, 3, "R3");
        do_write(16'h8000, 8'h00, 4, "R3");
        // R4: bank bit from A10, data ignored
        do_write(16'h8C00, 8'h00, 1, "R4");
        do_write(16'h8800, 8'hFF, 1, "R4");
        do_write(16'h8FFF, 8'h00, 1, "R4");
        // R5: X scroll and priority
        do_write(16'h9000, 8'h0B, 1, "R5");
        do_write(16'h9001, 8'h5A, 1, "R5");
        do_write(16'h9004, 8'h0E, 1, "R5");
        do_write(16'h9005, 8'hC3, 1, "R5");
        do_write(16'h9400, 8'hF5, 1, "R5");
        do_write(16'h97FD, 8'h81, 1, "R5");
        do_write(16'h97FC, 8'h07, 1, "R5");
        // R6: Y scroll
        do_write(16'h9002, 8'h77, 1, "R6");
        do_write(16'h9006, 8'h99, 1, "R6");
        do_write(16'h940A, 8'h3E, 1, "R6");
        do_write(16'h97FE, 8'hE1, 1, "R6");
        // R7: bank numbers, A2 ignored
        do_write(16'h9407, 8'hFE, 1, "R7");
        do_write(16'h9003, 8'h03, 1, "R7");
        do_write(16'h9007, 8'hFD, 1, "R7");
        // R8: background colour
        do_write(16'hC000, 8'hA5, 1, "R8");
        do_write(16'hC3FF, 8'h3C, 1, "R8");
        // R11: writes outside the control ranges
        do_write(16'h9800, 8'hFF, 1, "R11");
        do_write(16'hA000, 8'hFF, 1, "R11");
        do_write(16'hC400, 8'hFF, 1, "R11");
        do_write(16'h6000, 8'hFF, 1, "R11");
        do_write(16'h0000, 8'hFF, 1, "R11");
        // R9: ROM window steering
        set_addr(16'h6123, "R9");
        set_addr(16'h7FFF, "R9");
        set_addr(16'h5FFF, "R9");
        set_addr(16'hE000, "R9");
        do_write(16'h9003, 8'h02, 1, "R9");
        set_addr(16'h6ABC, "R9");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule